// File: doc/BRIEF.md
# Auto-Incrementing Packet Data Port

This block gives a host a narrow window into a packet buffer memory. The host writes a 16-bit pointer register that names which packet to reach and the byte offset inside it, then moves packet bytes or 16-bit words through a single data register. Each packet occupies a 256-byte page, so the byte address is the packet number times 256 plus the offset. The packet number comes from one of two inputs:

- the packet at the head of the receive queue;
- a packet-number value that the host has written elsewhere.

A pointer bit chooses between them.

When the pointer's auto-increment bit is set, every accepted data access moves the offset forward by the access size. Reads go through a one-word prefetch buffer. Writing the pointer with the read bit set, or completing a data access while the read bit is set, starts a fetch from the synchronous memory. A wait output stays high until the buffer holds the new word, and the port ignores data accesses while it is high. The queue logic, the page allocator and the memory itself sit outside this block.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer reads back as 0, `waitReq` is low, and neither `memRe` nor `memWe` is asserted.
- R2: With `regSel`=0, `rdData` returns the pointer. Bit 15 is the source select, bit 14 is auto-increment, bit 13 is read mode, and bits 10:0 are the offset. Bits 12:11 always read as zero.
- R3: Pointer bit 15 set selects `rxHeadPkt` as the packet; clear selects `txPktNum`. The word address driven on `memAddr` is (packet×256 + offset) / 2, rounded down.
- R4: An accepted word write (`regSel`=1, `wrEn`=1, `byteMode`=0) asserts `memWe` in the same cycle with `memBe`=11 and `memWdata` equal to `wrData`. `memRe` and `memWe` are never asserted together.
- R5: An accepted byte write asserts exactly one `memBe` bit: bit 0 for an even offset and bit 1 for an odd offset. `wrData[7:0]` appears on both byte lanes of `memWdata`.
- R6: With bit 14 set, each accepted data access adds 1 (byte) or 2 (word) to the offset, wrapping modulo 2048. With bit 14 clear the offset does not change.
- R7: A pointer write with bit 13 set raises `waitReq` for exactly the two following cycles. `memRe` is asserted in the first of those cycles, and the fetched word is readable once `waitReq` falls.
- R8: A word data read returns the prefetched memory word. A byte data read returns its low byte for an even offset or its high byte for an odd offset, zero-extended.
- R9: In read mode, each accepted data access starts a new two-cycle prefetch at the updated offset.
- R10: Data accesses presented while `waitReq` is high are ignored: no memory write and no offset change.
- R11: A pointer write with bit 13 clear starts no fetch, and `waitReq` stays low.
- R12: A pointer write during a pending prefetch restarts the prefetch with the new pointer.
- R13: A word access at an odd offset uses the word that contains that byte. The address is aligned down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register select: 0 pointer, 1 data |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (data register) |
| byteMode | input | 1 | 1 byte access, 0 word access |
| wrData | input | 16 | Host write data |
| rdData | output | 16 | Host read data (pointer or data register) |
| waitReq | output | 1 | Prefetch pending; data accesses ignored |
| rxHeadPkt | input | PKT_W | Packet number at the receive queue head |
| txPktNum | input | PKT_W | Host packet-number register value |
| memAddr | output | WORD_ADDR_W | Memory word address |
| memRe | output | 1 | Memory read enable (data one cycle later) |
| memWe | output | 1 | Memory write enable |
| memBe | output | 2 | Memory byte-lane enables |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, registered |

## Verification
- **Writes:** they reach the memory port in the cycle in which they are presented, so the bench checks `memWe`, `memAddr`, `memBe` and `memWdata` one nanosecond after driving them, before the next rising edge.
- **Pointer updates:** an offset change becomes visible on the pointer readback one edge after the access.
- **Prefetch:** after a pointer write or a read-mode access, the bench expects `waitReq` high at the next two falling edges, with `memRe` only at the first. It compares the data register against its own shadow of the memory at the third falling edge.
- **Sweeps:** they cover every packet number from both sources, offset wrap at 2047, both byte lanes, and odd-offset word reads.

// File: rtl/pdp_pkg.sv
`timescale 1ns/1ps
package pdp_pkg;

  localparam int PTR_W        = 16;
  localparam int DATA_W       = 16;
  localparam int LANE_W       = 8;
  localparam int LANES        = DATA_W / LANE_W;
  localparam int PTR_SRC_BIT  = 15;
  localparam int PTR_AUTO_BIT = 14;
  localparam int PTR_READ_BIT = 13;

  typedef enum logic [1:0] {
    PF_IDLE  = 2'd0,
    PF_FETCH = 2'd1,
    PF_LOAD  = 2'd2
  } pfState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrLoad;    // latch pointer from host data
    logic dataWrite;  // accepted data write
    logic advance;    // accepted data access (read or write)
    logic fetch;      // issue memory read
    logic capture;    // latch memory read data
  } pdpStrobe_t;

endpackage

// File: rtl/pdp_ctrl.sv
`timescale 1ns/1ps
module pdp_ctrl
  import pdp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       newReadMode,
  input  logic       curReadMode,
  output pdpStrobe_t st,
  output logic       waitReq
);

  pfState_e state, stateNext;
  logic ptrWr, idle, dataWr, dataRd;

  assign ptrWr  = !regSel && wrEn;
  assign idle   = (state == PF_IDLE);
  assign dataWr = regSel && wrEn && idle;
  assign dataRd = regSel && rdEn && !wrEn && idle;

  always_comb begin
    st           = '0;
    st.ptrLoad   = ptrWr;
    st.dataWrite = dataWr;
    st.advance   = dataWr || dataRd;
    st.fetch     = (state == PF_FETCH);
    st.capture   = (state == PF_LOAD);
  end

  always_comb begin
    stateNext = state;
    if (ptrWr) begin
      stateNext = newReadMode ? PF_FETCH : PF_IDLE;
    end else begin
      unique case (state)
        PF_IDLE:  if ((dataWr || dataRd) && curReadMode) stateNext = PF_FETCH;
        PF_FETCH: stateNext = PF_LOAD;
        PF_LOAD:  stateNext = PF_IDLE;
        default:  stateNext = PF_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PF_IDLE;
    else       state <= stateNext;
  end

  assign waitReq = !idle;

  // R7
  prefetch_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWr && newReadMode) |=> (waitReq && st.fetch));

  // R7
  prefetch_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.capture && !ptrWr) |=> !waitReq);

  // R11
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWr && !newReadMode) |=> (!waitReq && !st.fetch));

endmodule

// File: rtl/pdp_datapath.sv
`timescale 1ns/1ps
module pdp_datapath
  import pdp_pkg::*;
#(
  parameter int PKT_W       = 5,
  parameter int OFF_W       = 11,
  parameter int PAGE_SHIFT  = 8,
  parameter int WORD_ADDR_W = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pdpStrobe_t             st,
  input  logic                   regSel,
  input  logic                   byteMode,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [PKT_W-1:0]       rxHeadPkt,
  input  logic [PKT_W-1:0]       txPktNum,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [DATA_W-1:0]      rdData,
  output logic                   readMode,
  output logic [WORD_ADDR_W-1:0] memAddr,
  output logic                   memRe,
  output logic                   memWe,
  output logic [LANES-1:0]       memBe,
  output logic [DATA_W-1:0]      memWdata
);

  logic              srcSel, autoInc;
  logic [OFF_W-1:0]  offset, stepVal;
  logic [DATA_W-1:0] readBuf;
  logic [PKT_W-1:0]  pktNum;
  logic [PTR_W-1:0]  ptrView;
  logic [LANE_W-1:0] laneByte;

  assign stepVal = byteMode ? OFF_W'(1) : OFF_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel   <= 1'b0;
      autoInc  <= 1'b0;
      readMode <= 1'b0;
      offset   <= '0;
      readBuf  <= '0;
    end else begin
      if (st.ptrLoad) begin
        srcSel   <= wrData[PTR_SRC_BIT];
        autoInc  <= wrData[PTR_AUTO_BIT];
        readMode <= wrData[PTR_READ_BIT];
        offset   <= wrData[OFF_W-1:0];
      end else if (st.advance && autoInc) begin
        offset <= offset + stepVal;
      end
      if (st.capture) readBuf <= memRdata;
    end
  end

  // packet page base plus offset, expressed in words
  assign pktNum  = srcSel ? rxHeadPkt : txPktNum;
  assign memAddr = (WORD_ADDR_W'(pktNum) << (PAGE_SHIFT - 1))
                 + WORD_ADDR_W'(offset >> 1);
  assign memRe   = st.fetch;
  assign memWe   = st.dataWrite;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memBe[g] = !byteMode || (offset[0] == 1'(g));
    assign memWdata[g*LANE_W +: LANE_W] =
      byteMode ? wrData[LANE_W-1:0] : wrData[g*LANE_W +: LANE_W];
  end

  always_comb begin
    ptrView               = '0;
    ptrView[PTR_SRC_BIT]  = srcSel;
    ptrView[PTR_AUTO_BIT] = autoInc;
    ptrView[PTR_READ_BIT] = readMode;
    ptrView[OFF_W-1:0]    = offset;
  end

  assign laneByte = offset[0] ? readBuf[DATA_W-1 -: LANE_W] : readBuf[LANE_W-1:0];

  always_comb begin
    if (!regSel)       rdData = ptrView;
    else if (byteMode) rdData = DATA_W'(laneByte);
    else               rdData = readBuf;
  end

  // R6
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && autoInc && !st.ptrLoad) |=>
      (offset == OFF_W'($past(offset) + $past(stepVal))));

  // R6
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !autoInc && !st.ptrLoad) |=> $stable(offset));

  // R2
  ptr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.ptrLoad && !st.advance) |=> $stable({srcSel, autoInc, readMode, offset}));

  // R5
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && byteMode) |-> ($countones(memBe) == 1));

endmodule

// File: rtl/pkt_data_port.sv
`timescale 1ns/1ps
module pkt_data_port
  import pdp_pkg::*;
#(
  parameter  int PKT_W       = 5,
  parameter  int OFF_W       = 11,
  parameter  int PAGE_SHIFT  = 8,
  localparam int BYTE_ADDR_W = ((PKT_W + PAGE_SHIFT) > OFF_W) ? (PKT_W + PAGE_SHIFT + 1) : (OFF_W + 1),
  localparam int WORD_ADDR_W = BYTE_ADDR_W - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regSel,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic                   byteMode,
  input  logic [15:0]            wrData,
  output logic [15:0]            rdData,
  output logic                   waitReq,
  input  logic [PKT_W-1:0]       rxHeadPkt,
  input  logic [PKT_W-1:0]       txPktNum,
  output logic [WORD_ADDR_W-1:0] memAddr,
  output logic                   memRe,
  output logic                   memWe,
  output logic [1:0]             memBe,
  output logic [15:0]            memWdata,
  input  logic [15:0]            memRdata
);

  pdpStrobe_t st;
  logic       readMode;

  pdp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regSel      (regSel),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .newReadMode (wrData[PTR_READ_BIT]),
    .curReadMode (readMode),
    .st          (st),
    .waitReq     (waitReq)
  );

  pdp_datapath #(
    .PKT_W       (PKT_W),
    .OFF_W       (OFF_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .WORD_ADDR_W (WORD_ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .regSel    (regSel),
    .byteMode  (byteMode),
    .wrData    (wrData),
    .rxHeadPkt (rxHeadPkt),
    .txPktNum  (txPktNum),
    .memRdata  (memRdata),
    .rdData    (rdData),
    .readMode  (readMode),
    .memAddr   (memAddr),
    .memRe     (memRe),
    .memWe     (memWe),
    .memBe     (memBe),
    .memWdata  (memWdata)
  );

  // R4
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R10
  wait_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitReq && regSel) |-> !memWe);

endmodule

// File: tb/pkt_data_port_bench.sv
`timescale 1ns/1ps
module pkt_data_port_bench;

  localparam int PKT_W = 3;
  localparam int WORDS = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, byteMode = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        waitReq;
  logic [PKT_W-1:0] rxHeadPkt = '0, txPktNum = '0;
  logic [10:0] memAddr;
  logic        memRe, memWe;
  logic [1:0]  memBe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;

  logic [15:0] ram    [0:WORDS-1];
  logic [15:0] expMem [0:WORDS-1];

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkt_data_port #(.PKT_W(PKT_W)) u_pkt_data_port (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .byteMode(byteMode), .wrData(wrData), .rdData(rdData), .waitReq(waitReq),
    .rxHeadPkt(rxHeadPkt), .txPktNum(txPktNum), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // synchronous RAM model, one cycle read latency
  always @(posedge clk) begin
    if (memWe) begin
      if (memBe[0]) ram[memAddr][7:0]  <= memWdata[7:0];
      if (memBe[1]) ram[memAddr][15:8] <= memWdata[15:8];
    end
    if (memRe) memRdata <= ram[memAddr];
  end

  function automatic logic [15:0] pat(int i);
    return 16'((i * 40503) ^ 16'hC3A5);
  endfunction

  function automatic int wa(int pkt, int off);
    return (pkt * 256 + off) / 2;
  endfunction

  function automatic logic [15:0] ptrVal(bit src, bit ai, bit rd, int off);
    return {src, ai, rd, 2'b00, 11'(off)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ptrWrite(logic [15:0] v);
    @(negedge clk);
    regSel = 1'b0; rdEn = 1'b0; wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // called at the falling edge right after the triggering edge
  task automatic waitFetch(int expAddr, string req);
    chk(req, "waitReq fetch", int'(waitReq), 1);
    chk(req, "memRe fetch", int'(memRe), 1);
    chk(req, "memAddr fetch", int'(memAddr), expAddr);
    @(negedge clk);
    chk(req, "waitReq load", int'(waitReq), 1);
    chk(req, "memRe load", int'(memRe), 0);
    @(negedge clk);
    chk(req, "waitReq done", int'(waitReq), 0);
  endtask

  task automatic dataWrite(logic [15:0] v, bit bm, int expAddr, int expBe, logic [15:0] expWd, string req);
    regSel = 1'b1; rdEn = 1'b0; wrEn = 1'b1; byteMode = bm; wrData = v;
    #1;
    chk(req, "memWe", int'(memWe), 1);
    chk(req, "memAddr", int'(memAddr), expAddr);
    chk(req, "memBe", int'(memBe), expBe);
    chk(req, "memWdata", int'(memWdata), int'(expWd));
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic dataRead(bit bm, logic [15:0] exp, string req);
    regSel = 1'b1; wrEn = 1'b0; rdEn = 1'b1; byteMode = bm;
    #1;
    chk(req, "rdData", int'(rdData), int'(exp));
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readPtr(logic [15:0] exp, string req);
    regSel = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    #1;
    chk(req, "pointer", int'(rdData), int'(exp));
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      ram[i] = pat(i);
      expMem[i] = pat(i);
    end
    memRdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readPtr(16'h0000, "R1");
    chk("R1", "waitReq", int'(waitReq), 0);
    chk("R1", "memRe", int'(memRe), 0);
    chk("R1", "memWe", int'(memWe), 0);

    // R2 readback, reserved bits zero
    ptrWrite(16'hFFFF);
    waitFetch(wa(0, 2047), "R2");
    readPtr(16'hE7FF, "R2");
    // R11 pointer write without read mode
    ptrWrite(16'h1800);
    chk("R11", "waitReq", int'(waitReq), 0);
    chk("R11", "memRe", int'(memRe), 0);
    readPtr(16'h0000, "R2");

    // R3 R7 R8 sweep over every packet from both sources
    for (int src = 0; src < 2; src++) begin
      for (int p = 0; p < 8; p++) begin
        int off, sel, w;
        rxHeadPkt = PKT_W'(p);
        txPktNum  = PKT_W'(7 - p);
        off = (p * 37 + 5 + src * 600) & 2047;
        sel = src ? p : 7 - p;
        w = wa(sel, off);
        ptrWrite(ptrVal(src[0], 1'b0, 1'b1, off));
        waitFetch(w, "R3");
        dataRead(1'b0, expMem[w], "R8");
        waitFetch(w, "R9");
      end
    end

    // R4 R6 word writes with auto-increment across the offset wrap
    rxHeadPkt = 3'd5;
    txPktNum  = 3'd2;
    ptrWrite(ptrVal(1'b0, 1'b1, 1'b0, 2040));
    chk("R11", "waitReq", int'(waitReq), 0);
    for (int k = 0; k < 6; k++) begin
      int off, w;
      logic [15:0] v;
      off = (2040 + 2 * k) & 2047;
      w = wa(2, off);
      v = 16'hA000 + 16'(k * 16'h0111);
      dataWrite(v, 1'b0, w, 2'b11, v, "R4");
      expMem[w] = v;
    end
    readPtr(ptrVal(1'b0, 1'b1, 1'b0, 4), "R6");

    // R5 byte writes on both lanes
    ptrWrite(ptrVal(1'b0, 1'b1, 1'b0, 100));
    for (int k = 0; k < 5; k++) begin
      int off, w;
      logic [7:0] b;
      off = 100 + k;
      w = wa(2, off);
      b = 8'h30 + 8'(k * 8'h11);
      dataWrite({8'h5C, b}, 1'b1, w, (off & 1) ? 2 : 1, {b, b}, "R5");
      if (off & 1) expMem[w][15:8] = b;
      else         expMem[w][7:0]  = b;
    end
    readPtr(ptrVal(1'b0, 1'b1, 1'b0, 105), "R6");

    // R8 R9 byte reads with auto-increment and refetch
    ptrWrite(ptrVal(1'b0, 1'b1, 1'b1, 100));
    waitFetch(wa(2, 100), "R7");
    for (int k = 0; k < 5; k++) begin
      int off, w;
      logic [7:0] b;
      off = 100 + k;
      w = wa(2, off);
      b = (off & 1) ? expMem[w][15:8] : expMem[w][7:0];
      dataRead(1'b1, {8'h00, b}, "R8");
      waitFetch(wa(2, off + 1), "R9");
    end

    // R13 word read at odd offset, R6 no auto-increment
    ptrWrite(ptrVal(1'b0, 1'b0, 1'b1, 101));
    waitFetch(wa(2, 100), "R13");
    dataRead(1'b0, expMem[wa(2, 100)], "R13");
    waitFetch(wa(2, 100), "R9");
    readPtr(ptrVal(1'b0, 1'b0, 1'b1, 101), "R6");

    // R10 data write during a pending prefetch is ignored
    ptrWrite(ptrVal(1'b0, 1'b1, 1'b1, 200));
    regSel = 1'b1; wrEn = 1'b1; byteMode = 1'b0; wrData = 16'hDEAD;
    #1;
    chk("R10", "memWe in fetch", int'(memWe), 0);
    @(negedge clk);
    chk("R10", "memWe in load", int'(memWe), 0);
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10", "waitReq", int'(waitReq), 0);
    readPtr(ptrVal(1'b0, 1'b1, 1'b1, 200), "R10");
    dataRead(1'b0, expMem[wa(2, 200)], "R10");
    waitFetch(wa(2, 202), "R9");

    // R12 pointer write during fetch restarts the prefetch
    ptrWrite(ptrVal(1'b1, 1'b0, 1'b1, 10));
    chk("R12", "memAddr first", int'(memAddr), wa(5, 10));
    regSel = 1'b0; wrEn = 1'b1; wrData = ptrVal(1'b1, 1'b0, 1'b1, 50);
    @(negedge clk);
    wrEn = 1'b0;
    waitFetch(wa(5, 50), "R12");
    dataRead(1'b0, expMem[wa(5, 50)], "R12");
    waitFetch(wa(5, 50), "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule